// File: doc/BRIEF.md
# Tagged Receive FIFO with Service-Request Gating

This block buffers bytes arriving from a serial receiver (for example a slow infrared link) until the CPU or a DMA engine collects them. Every entry keeps the 8-bit data byte and a 3-bit tag. The receiver uses the tag to mark a byte that closes a frame or that arrived with an error. The read side is first-word fall-through: the oldest entry is always visible on the read port, and a read pulse moves to the next one.

Software sets a trigger level. When enough bytes have built up, the block asks the DMA engine for service. The block also looks at a window made of the oldest entries. The window holds as many entries as the trigger level, and never more than the current fill. If any entry in that window has a non-zero tag, a read-only status output goes high and an interrupt is raised that cannot be masked inside this block. While that status is high, DMA requests are held off, so that software can deal with the frame boundary or the error. Once the tagged bytes have been read out, requests come back on their own without any write from software.

A write to a full FIFO is lost and sets a sticky overrun flag. A one-cycle pulse on a clear input resets that flag.

Top module: `rx_tag_fifo`

## Requirements
- R1: Bytes and their tags leave on `rd_data` (data byte) and `rd_tag` (3-bit tag) in the order they were written. While the FIFO is non-empty, the oldest entry is visible on these outputs, and a read pulse moves them to the next entry on the following cycle.
- R2: `level` counts the stored entries. It rises by one for each accepted write and falls by one for each accepted read. `empty` is high exactly when `level` is 0, and `full` is high exactly when `level` equals DEPTH.
- R3: A write while `full` is high is discarded, and the stored contents stay as they were. In the next cycle `overrun` is 1 and it stays 1 until `ovr_clear` is pulsed. If a discarded write and the clear arrive in the same cycle, the flag stays set.
- R4: A read while `empty` is high has no effect: the next written byte is still the one that appears on `rd_data`.
- R5: `eoe_status` is 1 exactly when at least one of the oldest min(T, `level`) entries has a non-zero tag, where T is the effective trigger level. Tagged entries beyond that window do not set it.
- R6: `eoe_irq` is high in every cycle in which `eoe_status` is high and low otherwise. No input of the block can mask it.
- R7: `dma_req` is 1 exactly when `level` is at least T and `eoe_status` is 0.
- R8: After the tagged entries have been read out, `dma_req` comes back as soon as the R7 condition holds again, with no clear or other action from software.
- R9: The effective trigger level T is `trig_level`, except that a value of 0 acts as 1 and a value above DEPTH acts as DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Received byte |
| wr_tag | input | 3 | End-of-frame or error tag for the byte |
| rd_en | input | 1 | Read strobe from the CPU or DMA |
| rd_data | output | 8 | Oldest stored byte |
| rd_tag | output | 3 | Tag of the oldest stored byte |
| trig_level | input | $clog2(DEPTH+1) | Programmed trigger level |
| ovr_clear | input | 1 | Clear pulse for the overrun flag |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| empty | output | 1 | FIFO holds no entries |
| full | output | 1 | FIFO holds DEPTH entries |
| dma_req | output | 1 | DMA service request |
| eoe_irq | output | 1 | End/error interrupt |
| eoe_status | output | 1 | Read-only end/error-in-window status |
| overrun | output | 1 | Sticky flag for a lost write |

## Verification
The assertions check the following on every cycle:
- the fill never goes beyond the depth;
- a write to a full FIFO is dropped and the overrun flag is set;
- a read of an empty FIFO leaves it empty;
- the fill moves by exactly one for a lone write or a lone read;
- DMA requests are never raised while the end/error status is high;
- the status stays low while the FIFO is empty.

Some behaviours can only be shown by the directed scenarios in the bench:
- data order across the storage;
- the exact position of the tag window relative to the trigger level;
- the automatic return of DMA requests once the tagged byte is drained;
- the clamping of out-of-range trigger values.

// File: rtl/rx_tag_fifo_pkg.sv
package rx_tag_fifo_pkg;

  // Effective trigger: 0 behaves as 1, above depth behaves as depth
  function automatic int unsigned eff_trigger(int unsigned t, int unsigned d);
    if (t == 0) return 1;
    if (t > d) return d;
    return t;
  endfunction

  // Distance of a storage slot from the read pointer, in ring order
  function automatic int unsigned ring_dist(int unsigned idx, int unsigned rp, int unsigned d);
    return (idx >= rp) ? (idx - rp) : (idx + d - rp);
  endfunction

  // Size of the inspected window: trigger level limited by fill
  function automatic int unsigned window_span(int unsigned t, int unsigned fill);
    return (t < fill) ? t : fill;
  endfunction

endpackage

// File: rtl/rx_tag_fifo_store.sv
module rx_tag_fifo_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WORD_W = DATA_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              rd_en,
  output logic [WORD_W-1:0] head_word,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [CNT_W-1:0]  count,
  output logic [DEPTH-1:0]  tag_flag,
  output logic              wr_drop
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic              is_full, is_empty, wr_ok, rd_ok;

  function automatic logic [PTR_W-1:0] next_ptr(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_full  = (count == CNT_W'(DEPTH));
  assign is_empty = (count == '0);
  assign wr_ok    = wr_en && !is_full;
  assign rd_ok    = rd_en && !is_empty;
  assign wr_drop  = wr_en && is_full;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= {wr_tag, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      tag_flag <= '0;
    end else begin
      if (wr_ok) begin
        wr_ptr           <= next_ptr(wr_ptr);
        tag_flag[wr_ptr] <= |wr_tag;
      end
      if (rd_ok) rd_ptr <= next_ptr(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_word = mem[rd_ptr];

endmodule

// File: rtl/rx_tag_fifo_window.sv
module rx_tag_fifo_window
  import rx_tag_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] tag_flag,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] trig_level,
  output logic [CNT_W-1:0] eff_trig,
  output logic [DEPTH-1:0] win_mask,
  output logic             win_hit
);

  int unsigned span;

  always_comb begin
    eff_trig = CNT_W'(eff_trigger(32'(trig_level), DEPTH));
    span     = window_span(32'(eff_trig), 32'(count));
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign win_mask[g] = ring_dist(g, 32'(rd_ptr), DEPTH) < span;
  end

  assign win_hit = |(win_mask & tag_flag);

endmodule

// File: rtl/rx_tag_fifo_req.sv
module rx_tag_fifo_req #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] eff_trig,
  input  logic             win_hit,
  input  logic             wr_drop,
  input  logic             ovr_clear,
  output logic             dma_req,
  output logic             eoe_irq,
  output logic             overrun
);

  logic reached;

  assign reached = (count >= eff_trig);
  assign dma_req = reached && !win_hit;
  assign eoe_irq = win_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overrun <= 1'b0;
    else if (wr_drop)   overrun <= 1'b1;
    else if (ovr_clear) overrun <= 1'b0;
  end

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  input  logic [CNT_W-1:0]  trig_level,
  input  logic              ovr_clear,
  output logic [CNT_W-1:0]  level,
  output logic              empty,
  output logic              full,
  output logic              dma_req,
  output logic              eoe_irq,
  output logic              eoe_status,
  output logic              overrun
);

  logic [DATA_W+TAG_W-1:0] head_word;
  logic [PTR_W-1:0]        rd_ptr;
  logic [DEPTH-1:0]        tag_flag, win_mask;
  logic [CNT_W-1:0]        eff_trig;
  logic                    win_hit, wr_drop;

  rx_tag_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .rd_en(rd_en), .head_word(head_word), .rd_ptr(rd_ptr), .count(level),
    .tag_flag(tag_flag), .wr_drop(wr_drop)
  );

  rx_tag_fifo_window #(.DEPTH(DEPTH)) u_window (
    .tag_flag(tag_flag), .rd_ptr(rd_ptr), .count(level), .trig_level(trig_level),
    .eff_trig(eff_trig), .win_mask(win_mask), .win_hit(win_hit)
  );

  rx_tag_fifo_req #(.DEPTH(DEPTH)) u_req (
    .clk(clk), .rst_n(rst_n), .count(level), .eff_trig(eff_trig), .win_hit(win_hit),
    .wr_drop(wr_drop), .ovr_clear(ovr_clear), .dma_req(dma_req), .eoe_irq(eoe_irq),
    .overrun(overrun)
  );

  assign rd_data    = head_word[DATA_W-1:0];
  assign rd_tag     = head_word[DATA_W+TAG_W-1:DATA_W];
  assign eoe_status = win_hit;
  assign empty      = (level == '0);
  assign full       = (level == CNT_W'(DEPTH));

endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [CNT_W-1:0] level,
  input logic             empty,
  input logic             full,
  input logic             dma_req,
  input logic             eoe_status,
  input logic             overrun,
  input logic             wr_drop
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH)); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> $stable(level)); // R3

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> overrun); // R3

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> empty); // R4

  AST_LEVEL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && !rd_en) |=> (level == $past(level) + 1'b1)); // R2

  AST_LEVEL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty && !wr_en) |=> (level == $past(level) - 1'b1)); // R2

  AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    eoe_status |-> !dma_req); // R7

  AST_EMPTY_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !eoe_status); // R5

endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .level(level),
  .empty(empty), .full(full), .dma_req(dma_req), .eoe_status(eoe_status),
  .overrun(overrun), .wr_drop(wr_drop)
);

// File: tb/rx_tag_fifo_test.sv
module rx_tag_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, ovr_clear = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_tag = 0;
  logic [CNT_W-1:0] trig_level = 1;
  logic [7:0] rd_data;
  logic [2:0] rd_tag;
  logic [CNT_W-1:0] level;
  logic empty, full, dma_req, eoe_irq, eoe_status, overrun;

  int tests = 0, fails = 0;

  rx_tag_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag), .trig_level(trig_level),
    .ovr_clear(ovr_clear), .level(level), .empty(empty), .full(full),
    .dma_req(dma_req), .eoe_irq(eoe_irq), .eoe_status(eoe_status), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(int d, int t);
    @(negedge clk); wr_en = 1; wr_data = 8'(d); wr_tag = 3'(t);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pop_expect(string req, int d, int t);
    @(negedge clk);
    check(req, rd_data, d);
    check(req, rd_tag, t);
    rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic drain();
    while (!empty) begin
      @(negedge clk); rd_en = 1;
      @(negedge clk); rd_en = 0;
    end
  endtask

  task automatic t_reset();
    check("R2 reset level", level, 0);
    check("R2 reset empty", empty, 1);
    check("R2 reset full", full, 0);
    check("R7 reset dma", dma_req, 0);
    check("R6 reset irq", eoe_irq, 0);
    check("R3 reset overrun", overrun, 0);
  endtask

  task automatic t_order();
    trig_level = 4;
    for (int i = 0; i < 3; i++) push(8'h10 + i, 0);
    check("R7 below trigger", dma_req, 0);
    push(8'h13, 0);
    check("R7 at trigger", dma_req, 1);
    check("R2 level 4", level, 4);
    for (int i = 0; i < 4; i++) pop_expect("R1 order", 8'h10 + i, 0);
    check("R2 empty after drain", empty, 1);
  endtask

  task automatic t_window();
    trig_level = 4;
    for (int i = 0; i < 4; i++) push(8'h20 + i, 0);
    push(8'h24, 5);
    check("R5 tag outside window", eoe_status, 0);
    check("R7 dma with tag outside", dma_req, 1);
    pop_expect("R1 window head", 8'h20, 0);
    check("R5 tag enters window", eoe_status, 1);
    check("R6 irq follows", eoe_irq, 1);
    check("R7 dma blocked", dma_req, 0);
    for (int i = 1; i < 4; i++) pop_expect("R1 window seq", 8'h20 + i, 0);
    check("R5 tag oldest", eoe_status, 1);
    pop_expect("R1 tagged byte", 8'h24, 5);
    check("R8 status cleared", eoe_status, 0);
    check("R6 irq cleared", eoe_irq, 0);
    for (int i = 0; i < 4; i++) push(8'h30 + i, 0);
    check("R8 dma resumes", dma_req, 1);
    drain();
    push(8'h40, 2);
    check("R5 window limited by fill", eoe_status, 1);
    check("R7 below trigger blocked", dma_req, 0);
    drain();
  endtask

  task automatic t_overrun();
    trig_level = CNT_W'(DEPTH);
    for (int i = 0; i < DEPTH; i++) push(i, 0);
    check("R2 full", full, 1);
    check("R7 dma at full", dma_req, 1);
    check("R3 no overrun yet", overrun, 0);
    push(8'hEE, 0);
    check("R3 level held", level, DEPTH);
    check("R3 overrun set", overrun, 1);
    @(negedge clk); wr_en = 1; wr_data = 8'hEF; ovr_clear = 1;
    @(negedge clk); wr_en = 0; ovr_clear = 0;
    check("R3 set beats clear", overrun, 1);
    @(negedge clk); ovr_clear = 1;
    @(negedge clk); ovr_clear = 0;
    check("R3 overrun cleared", overrun, 0);
    for (int i = 0; i < DEPTH; i++) pop_expect("R3 contents kept", i, 0);
    check("R2 empty", empty, 1);
  endtask

  task automatic t_empty_read();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    check("R4 level stays 0", level, 0);
    push(8'h5A, 1);
    pop_expect("R4 next write visible", 8'h5A, 1);
  endtask

  task automatic t_clamp();
    trig_level = 0;
    push(8'h61, 0);
    check("R9 zero acts as one", dma_req, 1);
    drain();
    trig_level = CNT_W'(100);
    for (int i = 0; i < DEPTH - 1; i++) push(i, 0);
    check("R9 large below depth", dma_req, 0);
    push(8'h77, 0);
    check("R9 large acts as depth", dma_req, 1);
    drain();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_window();
    t_overrun();
    t_empty_read();
    t_clamp();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule